// File: doc/BRIEF.md
# Audio Port Register and FIFO Controller

This block sits between a 32-bit register bus and a serial audio port. Software programs run, clocking-direction, format and divider settings through a small register set. Sample data moves through two 32-entry FIFOs that share one data address. A bus write to that address queues a playback sample and a bus read takes the oldest captured sample. A DMA engine can drive the FIFOs instead of software. The block raises a playback DMA request while the playback FIFO is low, and a capture request while the capture FIFO is high. Both limits are programmable.

On the audio side the block hands samples to a serializer and takes samples from a deserializer, each over a valid/ready stream. The playback stream never stalls the serializer. When the serializer takes a sample from an empty FIFO, that is an underrun: the block sends either zero or the previous sample again, depending on a hold-last option. The capture stream accepts every offered sample while capture runs. A sample that arrives with the FIFO full is dropped and flags an overrun. Both error flags are sticky, cleared by writing 1, and can each raise the interrupt. A loopback mode sends played samples straight into the capture FIFO. There is also a FIFO flush bit and a whole-block soft reset, and both clear themselves.

Top module: `aud_port_ctrl`

## Requirements
- R1: After reset, reads return 0x0000_7800 at 0x00 (playback limit 8 in bits 11:8, capture limit 7 in bits 15:12) and 0 at 0x04, 0x10, 0x14, 0x1C and 0x30. The outputs tx_valid, rx_ready, irq and both DMA requests are low.
- R2: A write to 0x34 queues bus_wdata[15:0] in the playback FIFO and raises the playback level, which reads at 0x14 bits 13:8. A write made while 32 samples are held is discarded.
- R3: A read of 0x34 returns the oldest capture sample, zero-extended, and removes it. A read with the capture FIFO empty returns 0 and leaves the level (0x14 bits 5:0) at 0.
- R4: tx_valid equals config bit 0 (run) AND control bit 1 (playback). Each tx_valid&&tx_ready cycle hands out the next queued sample, in write order.
- R5: A handshake with the playback FIFO empty sets the sticky underrun flag (0x14 bit 16). While the FIFO is empty, tx_data is 0 if config bit 6 is clear, and the last sample handed out if config bit 6 is set.
- R6: rx_ready equals run AND control bit 0 (capture) AND NOT control bit 2 (loopback). Accepted samples enter the capture FIFO. A sample accepted while the FIFO is full is dropped and sets the sticky overrun flag (0x14 bit 17).
- R7: With loopback, capture, playback and run set, every sample handed out on the playback stream is also queued in the capture FIFO.
- R8: Writing 1 to 0x14 bit 16 or bit 17 clears that flag. Writing 0 leaves it unchanged.
- R9: tx_dma_req = control bit 14 AND (playback level <= config bits 11:8). rx_dma_req = control bit 15 AND (capture level >= config bits 15:12).
- R10: A control write with bit 8 set empties both FIFOs by the next cycle. Bit 8 reads back as 0, and the other bits of that write are stored.
- R11: A config write with bit 3 set returns every register, flag and FIFO to its reset value (R1) in the next cycle, and the rest of that write is discarded.
- R12: irq is the OR of four terms: control bit 3 with the playback-low condition of R9, control bit 4 with the capture-high condition, control bit 5 with the underrun flag, and control bit 6 with the overrun flag.
- R13: 0x10 stores all 32 bits and drives fmt_word. 0x30 stores bits 3:0 and 11:8 and drives clk_div. 0x1C bit 2 reads run AND (capture OR playback). port_run, fclk_drive and bclk_drive follow config bits 0, 1 and 2. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Playback sample offered |
| tx_ready | input | 1 | Serializer takes the sample |
| tx_data | output | 16 | Playback sample |
| rx_valid | input | 1 | Capture sample offered |
| rx_ready | output | 1 | Block accepts capture samples |
| rx_data | input | 16 | Capture sample |
| tx_dma_req | output | 1 | Playback DMA request |
| rx_dma_req | output | 1 | Capture DMA request |
| irq | output | 1 | Interrupt |
| port_run | output | 1 | Port enabled |
| fclk_drive | output | 1 | Block drives frame clock |
| bclk_drive | output | 1 | Block drives bit clock |
| fmt_word | output | 32 | Stored format word |
| clk_div | output | 8 | Stored dividers, playback in 3:0, capture in 7:4 |

## Verification
The bench fills both FIFOs past 32 entries. A design with a wrong full test would either wrap the level around or corrupt the oldest samples. It takes one sample from an empty playback FIFO with hold-last both clear and set. A design that mixes the two modes up would send a stale sample or a silent zero. It also checks that the flag stays sticky against a write of 0. It reads the capture port while empty, where a broken pop guard would underflow the level. It flushes and soft-resets with data in flight, and reads back the self-clearing bits. It sweeps random threshold limits against random fill levels to catch off-by-one errors at the DMA request boundaries.

// File: rtl/aud_pkg.sv
package aud_pkg;

  localparam logic [7:0] A_CFG = 8'h00;
  localparam logic [7:0] A_CTL = 8'h04;
  localparam logic [7:0] A_FMT = 8'h10;
  localparam logic [7:0] A_FST = 8'h14;
  localparam logic [7:0] A_PST = 8'h1C;
  localparam logic [7:0] A_DIV = 8'h30;
  localparam logic [7:0] A_DAT = 8'h34;

  localparam int B_SOFTRST = 3;
  localparam int B_FLUSH   = 8;
  localparam int B_UNR     = 16;
  localparam int B_OVR     = 17;

  typedef struct packed {
    logic [3:0] rx_thr;
    logic [3:0] tx_thr;
    logic       hold_last;
    logic       int_codec;
    logic       i2s_mode;
    logic       bclk_drv;
    logic       fclk_drv;
    logic       run;
  } cfg_t;

  typedef struct packed {
    logic rx_dma;
    logic tx_dma;
    logic ovr_ie;
    logic unr_ie;
    logic rxs_ie;
    logic txs_ie;
    logic loop;
    logic play;
    logic cap;
  } ctl_t;

  function automatic cfg_t cfg_default();
    cfg_t c;
    c = '0;
    c.tx_thr = 4'd8;
    c.rx_thr = 4'd7;
    return c;
  endfunction

  function automatic cfg_t cfg_from_word(logic [31:0] w);
    cfg_t c;
    c.run       = w[0];
    c.fclk_drv  = w[1];
    c.bclk_drv  = w[2];
    c.i2s_mode  = w[4];
    c.int_codec = w[5];
    c.hold_last = w[6];
    c.tx_thr    = w[11:8];
    c.rx_thr    = w[15:12];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(cfg_t c);
    return {16'd0, c.rx_thr, c.tx_thr, 1'b0, c.hold_last, c.int_codec,
            c.i2s_mode, 1'b0, c.bclk_drv, c.fclk_drv, c.run};
  endfunction

  function automatic ctl_t ctl_from_word(logic [31:0] w);
    ctl_t k;
    k.cap    = w[0];
    k.play   = w[1];
    k.loop   = w[2];
    k.txs_ie = w[3];
    k.rxs_ie = w[4];
    k.unr_ie = w[5];
    k.ovr_ie = w[6];
    k.tx_dma = w[14];
    k.rx_dma = w[15];
    return k;
  endfunction

  function automatic logic [31:0] ctl_to_word(ctl_t k);
    return {16'd0, k.rx_dma, k.tx_dma, 7'd0, k.ovr_ie, k.unr_ie,
            k.rxs_ie, k.txs_ie, k.loop, k.play, k.cap};
  endfunction

endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

  // R2: the level never passes the depth
  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2: a push into a full FIFO without a pop leaves it full
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);

  // R10: a clear empties the FIFO
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/aud_regs.sv
module aud_regs
  import aud_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int LVL_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [LVL_W-1:0]    tx_level,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [SAMPLE_W-1:0] rx_head,
  input  logic                rx_empty,
  input  logic                unr_set,
  input  logic                ovr_set,
  output cfg_t                cfg_q,
  output ctl_t                ctl_q,
  output logic [31:0]         fmt_q,
  output logic [7:0]          div_q,
  output logic                fifo_clr,
  output logic                soft_rst,
  output logic                tx_push,
  output logic                rx_pop,
  output logic                tx_dma_req,
  output logic                rx_dma_req,
  output logic                irq
);
  logic wr, rd;
  logic hit_cfg, hit_ctl, hit_fmt, hit_fst, hit_div, hit_dat;
  logic unr_q, ovr_q;
  logic flush_p;
  logic tx_low, rx_high, busy;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign hit_cfg = (bus_addr == ADDR_W'(A_CFG));
  assign hit_ctl = (bus_addr == ADDR_W'(A_CTL));
  assign hit_fmt = (bus_addr == ADDR_W'(A_FMT));
  assign hit_fst = (bus_addr == ADDR_W'(A_FST));
  assign hit_div = (bus_addr == ADDR_W'(A_DIV));
  assign hit_dat = (bus_addr == ADDR_W'(A_DAT));

  assign soft_rst = wr & hit_cfg & bus_wdata[B_SOFTRST];
  assign flush_p  = wr & hit_ctl & bus_wdata[B_FLUSH];
  assign fifo_clr = soft_rst | flush_p;
  assign tx_push  = wr & hit_dat;
  assign rx_pop   = rd & hit_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= cfg_default();
      ctl_q <= '0;
      fmt_q <= '0;
      div_q <= '0;
      unr_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (soft_rst) begin
      cfg_q <= cfg_default();
      ctl_q <= '0;
      fmt_q <= '0;
      div_q <= '0;
      unr_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (wr && hit_cfg) cfg_q <= cfg_from_word(bus_wdata);
      if (wr && hit_ctl) ctl_q <= ctl_from_word(bus_wdata);
      if (wr && hit_fmt) fmt_q <= bus_wdata;
      if (wr && hit_div) div_q <= {bus_wdata[11:8], bus_wdata[3:0]};
      unr_q <= (unr_q & ~(wr & hit_fst & bus_wdata[B_UNR])) | unr_set;
      ovr_q <= (ovr_q & ~(wr & hit_fst & bus_wdata[B_OVR])) | ovr_set;
    end
  end

  assign tx_low  = 32'(tx_level) <= 32'(cfg_q.tx_thr);
  assign rx_high = 32'(rx_level) >= 32'(cfg_q.rx_thr);
  assign busy    = cfg_q.run & (ctl_q.cap | ctl_q.play);

  assign tx_dma_req = ctl_q.tx_dma & tx_low;
  assign rx_dma_req = ctl_q.rx_dma & rx_high;
  assign irq = (ctl_q.txs_ie & tx_low) | (ctl_q.rxs_ie & rx_high) |
               (ctl_q.unr_ie & unr_q)  | (ctl_q.ovr_ie & ovr_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CFG): bus_rdata = cfg_to_word(cfg_q);
      ADDR_W'(A_CTL): bus_rdata = ctl_to_word(ctl_q);
      ADDR_W'(A_FMT): bus_rdata = fmt_q;
      ADDR_W'(A_FST): bus_rdata = {14'd0, ovr_q, unr_q, 2'd0, 6'(tx_level),
                                   2'd0, 6'(rx_level)};
      ADDR_W'(A_PST): bus_rdata = {29'd0, busy, 2'd0};
      ADDR_W'(A_DIV): bus_rdata = {20'd0, div_q[7:4], 4'd0, div_q[3:0]};
      ADDR_W'(A_DAT): bus_rdata = rx_empty ? '0 : 32'(rx_head);
      default:        bus_rdata = '0;
    endcase
  end

  // R10: a flush write leaves both FIFOs empty
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_p |=> (tx_level == '0 && rx_level == '0));

  // R11: a soft reset restores defaults everywhere
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_q == cfg_default() && ctl_q == '0 && !unr_q && !ovr_q &&
                  tx_level == '0 && rx_level == '0));

  // R5: an underrun event is captured in the flag
  p_unr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unr_set && !soft_rst) |=> unr_q);

  // R6: an overrun event is captured in the flag
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_set && !soft_rst) |=> ovr_q);

endmodule

// File: rtl/aud_stream.sv
module aud_stream #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                run,
  input  logic                play,
  input  logic                cap,
  input  logic                loop,
  input  logic                hold_last,
  input  logic [SAMPLE_W-1:0] tx_head,
  input  logic                tx_empty,
  input  logic                rx_full,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic [SAMPLE_W-1:0] tx_data,
  output logic                tx_pop,
  input  logic                rx_valid,
  input  logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_ready,
  output logic                rx_push,
  output logic [SAMPLE_W-1:0] rx_wdata,
  output logic                unr_set,
  output logic                ovr_set
);
  logic [SAMPLE_W-1:0] last_q;
  logic tx_fire, lb_fire, rx_fire;

  assign tx_valid = run & play;
  assign tx_fire  = tx_valid & tx_ready;
  assign tx_pop   = tx_fire & ~tx_empty;
  assign unr_set  = tx_fire & tx_empty;
  assign tx_data  = !tx_empty ? tx_head : (hold_last ? last_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= '0;
    else if (soft_rst) last_q <= '0;
    else if (tx_pop)   last_q <= tx_head;
  end

  assign rx_ready = run & cap & ~loop;
  assign lb_fire  = run & cap & loop & tx_fire;
  assign rx_fire  = (rx_valid & rx_ready) | lb_fire;
  assign rx_wdata = loop ? tx_data : rx_data;
  assign rx_push  = rx_fire & ~rx_full;
  assign ovr_set  = rx_fire & rx_full;

  // R7: in loopback the capture FIFO is fed only by playback handshakes
  p_loop_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop && rx_push) |-> (tx_valid && tx_ready));

  // R5: with hold-last, an empty FIFO keeps repeating the same sample
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && hold_last && !soft_rst) |=> (!tx_empty || !hold_last || $stable(tx_data)));

endmodule

// File: rtl/aud_port_ctrl.sv
module aud_port_ctrl
  import aud_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [SAMPLE_W-1:0] tx_data,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [SAMPLE_W-1:0] rx_data,
  output logic                tx_dma_req,
  output logic                rx_dma_req,
  output logic                irq,
  output logic                port_run,
  output logic                fclk_drive,
  output logic                bclk_drive,
  output logic [31:0]         fmt_word,
  output logic [7:0]          clk_div
);
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam int NCH   = 2;
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;

  cfg_t cfg_q;
  ctl_t ctl_q;
  logic fifo_clr, soft_rst, tx_push, rx_pop, unr_set, ovr_set;
  logic tx_pop, rx_push;
  logic [SAMPLE_W-1:0] rx_wdata;

  logic [NCH-1:0]      f_push, f_pop, f_full, f_empty;
  logic [SAMPLE_W-1:0] f_wd [NCH];
  logic [SAMPLE_W-1:0] f_hd [NCH];
  logic [LVL_W-1:0]    f_lvl [NCH];

  assign f_push[CH_TX] = tx_push;
  assign f_pop[CH_TX]  = tx_pop;
  assign f_wd[CH_TX]   = bus_wdata[SAMPLE_W-1:0];
  assign f_push[CH_RX] = rx_push;
  assign f_pop[CH_RX]  = rx_pop;
  assign f_wd[CH_RX]   = rx_wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_fifo
    aud_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fifo_clr),
      .push  (f_push[g]),
      .wdata (f_wd[g]),
      .pop   (f_pop[g]),
      .head  (f_hd[g]),
      .level (f_lvl[g]),
      .full  (f_full[g]),
      .empty (f_empty[g])
    );
  end

  aud_regs #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .LVL_W(LVL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_level   (f_lvl[CH_TX]),
    .rx_level   (f_lvl[CH_RX]),
    .rx_head    (f_hd[CH_RX]),
    .rx_empty   (f_empty[CH_RX]),
    .unr_set    (unr_set),
    .ovr_set    (ovr_set),
    .cfg_q      (cfg_q),
    .ctl_q      (ctl_q),
    .fmt_q      (fmt_word),
    .div_q      (clk_div),
    .fifo_clr   (fifo_clr),
    .soft_rst   (soft_rst),
    .tx_push    (tx_push),
    .rx_pop     (rx_pop),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req),
    .irq        (irq)
  );

  aud_stream #(.SAMPLE_W(SAMPLE_W)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .run       (cfg_q.run),
    .play      (ctl_q.play),
    .cap       (ctl_q.cap),
    .loop      (ctl_q.loop),
    .hold_last (cfg_q.hold_last),
    .tx_head   (f_hd[CH_TX]),
    .tx_empty  (f_empty[CH_TX]),
    .rx_full   (f_full[CH_RX]),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_pop    (tx_pop),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .rx_push   (rx_push),
    .rx_wdata  (rx_wdata),
    .unr_set   (unr_set),
    .ovr_set   (ovr_set)
  );

  assign port_run   = cfg_q.run;
  assign fclk_drive = cfg_q.fclk_drv;
  assign bclk_drive = cfg_q.bclk_drv;

  // R4: playback samples are offered only while run and playback are set
  p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (port_run && ctl_q.play));

endmodule

// File: tb/aud_port_ctrl_test.sv
module aud_port_ctrl_test;
  localparam logic [7:0] A_CFG = 8'h00, A_CTL = 8'h04, A_FMT = 8'h10, A_FST = 8'h14,
                         A_PST = 8'h1C, A_DIV = 8'h30, A_DAT = 8'h34;
  localparam int G_RUN = 1, G_FCLK = 2, G_BCLK = 4, G_RST = 8, G_HOLD = 64;
  localparam int C_CAP = 1, C_PLAY = 2, C_LOOP = 4, C_TXS = 8, C_RXS = 16,
                 C_UNR = 32, C_OVR = 64, C_FLUSH = 256, C_TXDMA = 1 << 14, C_RXDMA = 1 << 15;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [15:0] tx_data, rx_data = 0;
  logic tx_dma_req, rx_dma_req, irq, port_run, fclk_drive, bclk_drive;
  logic [31:0] fmt_word;
  logic [7:0] clk_div;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  logic [15:0] last_tx;

  aud_port_ctrl uut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] cfg_word(int txt, int rxt, int flags);
    return 32'(flags) | (32'(rxt & 15) << 12) | (32'(txt & 15) << 8);
  endfunction

  function automatic logic [31:0] fst_word(int txl, int rxl, bit u, bit o);
    return {14'd0, o, u, 2'd0, 6'(txl), 2'd0, 6'(rxl)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic push_tx(int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      if (txq.size() < 32) txq.push_back(v);
      wr(A_DAT, {16'hDEAD, v});
    end
  endtask

  task automatic send_rx(int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      @(negedge clk);
      rx_valid = 1; rx_data = v;
      if (rxq.size() < 32) rxq.push_back(v);
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    rd(A_CFG, d); chk("R1 cfg", d, 32'h0000_7800);
    rd(A_CTL, d); chk("R1 ctl", d, 0);
    rd(A_FMT, d); chk("R1 fmt", d, 0);
    rd(A_FST, d); chk("R1 fstat", d, 0);
    rd(A_PST, d); chk("R1 pstat", d, 0);
    rd(A_DIV, d); chk("R1 div", d, 0);
    chk("R1 outputs", {27'd0, tx_valid, rx_ready, irq, tx_dma_req, rx_dma_req}, 0);

    // R13 storage, status and unmapped space
    wr(A_FMT, 32'hA5A5_1234); rd(A_FMT, d); chk("R13 fmt", d, 32'hA5A5_1234);
    chk("R13 fmt_word", fmt_word, 32'hA5A5_1234);
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, d); chk("R13 div", d, 32'h0000_0F0F);
    chk("R13 clk_div", 32'(clk_div), 32'hFF);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R13 unmapped", d, 0);
    wr(A_CFG, cfg_word(8, 7, G_RUN | G_FCLK | G_BCLK));
    wr(A_CTL, C_CAP);
    rd(A_PST, d); chk("R13 busy", d, 32'h4);
    chk("R13 pins", {29'd0, port_run, fclk_drive, bclk_drive}, 32'h7);
    wr(A_CTL, 0);
    rd(A_PST, d); chk("R13 idle", d, 0);

    // R2 R4 R9 R12 random playback bursts
    for (int it = 0; it < 4; it++) begin
      int n, thr;
      n = 1 + int'($urandom % 20);
      thr = int'($urandom % 16);
      wr(A_CFG, cfg_word(thr, 7, G_RUN));
      wr(A_CTL, C_TXDMA | C_TXS);
      push_tx(n);
      rd(A_FST, d); chk("R2 tx level", d, fst_word(n, 0, 0, 0));
      chk("R9 tx dma", 32'(tx_dma_req), 32'(n <= thr));
      chk("R12 tx service irq", 32'(irq), 32'(n <= thr));
      wr(A_CTL, C_PLAY);
      chk("R4 valid", 32'(tx_valid), 1);
      @(negedge clk);
      tx_ready = 1;
      for (int i = 0; i < n; i++) begin
        #1 chk("R4 order", 32'(tx_data), 32'(txq[0]));
        last_tx = txq.pop_front();
        @(negedge clk);
      end
      tx_ready = 0;
      rd(A_FST, d); chk("R4 drained", d, fst_word(0, 0, 0, 0));
    end

    // R5 underrun with and without hold-last; R8 clearing; R12 irq
    wr(A_CFG, cfg_word(8, 7, G_RUN));
    #1 chk("R5 zero fill", 32'(tx_data), 0);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    rd(A_FST, d); chk("R5 underrun flag", d, fst_word(0, 0, 1, 0));
    wr(A_CTL, C_PLAY | C_UNR);
    chk("R12 underrun irq", 32'(irq), 1);
    wr(A_CFG, cfg_word(8, 7, G_RUN | G_HOLD));
    #1 chk("R5 hold last", 32'(tx_data), 32'(last_tx));
    wr(A_FST, 0); rd(A_FST, d); chk("R8 write 0 keeps", d, fst_word(0, 0, 1, 0));
    wr(A_FST, 32'h0001_0000); rd(A_FST, d); chk("R8 write 1 clears", d, 0);
    chk("R12 irq drops", 32'(irq), 0);
    wr(A_CTL, 0);

    // R6 R3 R9 R12 random capture bursts
    for (int it = 0; it < 4; it++) begin
      int m, thr;
      m = 1 + int'($urandom % 20);
      thr = int'($urandom % 16);
      wr(A_CFG, cfg_word(8, thr, G_RUN));
      wr(A_CTL, C_CAP | C_RXDMA | C_RXS);
      chk("R6 ready", 32'(rx_ready), 1);
      send_rx(m);
      rd(A_FST, d); chk("R6 rx level", d, fst_word(0, m, 0, 0));
      chk("R9 rx dma", 32'(rx_dma_req), 32'(m >= thr));
      chk("R12 rx service irq", 32'(irq & rx_dma_req), 32'(m >= thr));
      for (int i = 0; i < m; i++) begin
        rd(A_DAT, d); chk("R3 pop data", d, 32'(rxq.pop_front()));
      end
      rd(A_DAT, d); chk("R3 empty read", d, 0);
      rd(A_FST, d); chk("R3 level stays 0", d, 0);
    end

    // R6 overrun
    send_rx(33);
    rd(A_FST, d); chk("R6 overrun", d, fst_word(0, 32, 0, 1));
    rd(A_DAT, d); chk("R6 oldest kept", d, 32'(rxq.pop_front()));
    wr(A_CTL, 0);

    // R2 full playback FIFO, then R10 flush
    push_tx(35);
    rd(A_FST, d); chk("R2 full cap", d, fst_word(32, 31, 0, 1));
    chk("R9 tx dma full", 32'(tx_dma_req), 0);
    wr(A_CTL, C_FLUSH | C_TXS | C_CAP);
    rd(A_CTL, d); chk("R10 flush self clears", d, C_TXS | C_CAP);
    rd(A_FST, d); chk("R10 fifos empty", d, fst_word(0, 0, 0, 1));
    txq.delete(); rxq.delete();
    wr(A_FST, 32'h0002_0000);

    // R7 loopback
    wr(A_CTL, C_CAP | C_PLAY | C_LOOP);
    chk("R7 rx_ready off", 32'(rx_ready), 0);
    push_tx(3);
    @(negedge clk); tx_ready = 1;
    repeat (3) @(negedge clk);
    tx_ready = 0;
    rd(A_FST, d); chk("R7 looped level", d, fst_word(0, 3, 0, 0));
    for (int i = 0; i < 3; i++) begin
      rd(A_DAT, d); chk("R7 looped data", d, 32'(txq.pop_front()));
    end

    // R11 soft reset with state in flight
    wr(A_CFG, cfg_word(3, 2, G_RUN | G_HOLD));
    wr(A_CTL, C_PLAY | C_TXDMA);
    wr(A_FMT, 32'h1111_2222);
    push_tx(4);
    wr(A_CFG, G_RST | G_RUN);
    rd(A_CFG, d); chk("R11 cfg", d, 32'h0000_7800);
    rd(A_CTL, d); chk("R11 ctl", d, 0);
    rd(A_FMT, d); chk("R11 fmt", d, 0);
    rd(A_FST, d); chk("R11 fstat", d, 0);
    chk("R11 outputs", {30'd0, tx_valid, tx_dma_req}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule